// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it may accept one operation: a 4-bit operation code, two data operands and the current status flags. One clock edge later it presents the new data value, a strobe saying whether that value should be written back, and the updated negative, overflow, zero and carry flags. Every operation class touches its own fixed group of flags. All other flags are copied from the input unchanged, so the surrounding core can always write the flag output into its status register.

Binary addition and subtraction take their carry from the incoming carry flag. Compare and bit test produce flags only. Increment, decrement, the two shifts and the two rotates work on operand A. Rotates pass data through the carry flag. Decimal arithmetic, operand fetch and addressing are left to other blocks.

Top module: `alu8_flags`

## Requirements
- R1: While reset is asserted, all outputs read zero: result, write-back strobe, flags and output-valid.
- R2: An operation accepted on a clock edge shows up on the outputs at that edge, with outValid high. If no operation is accepted, outValid and resultWe are low on the following cycle, and result and flagsOut keep their values.
- R3: Code 0 adds A + B + C. Code 1 subtracts as A + ~B + C, so C=1 means no borrow. Both write the result back and update all four flags. C is the unsigned carry-out, and V is set when the true signed result does not fit in 8 bits.
- R4: Code 2 compares A with B. C is set when A >= B unsigned, Z is set when A equals B, and N is bit 7 of A - B. V passes through, resultWe is low and the result output keeps its value.
- R5: Codes 3, 4 and 5 compute A AND B, A OR B and A XOR B. They write the value back and update only N and Z; V and C pass through.
- R6: Code 6 is a bit test. Z is set when A AND B is zero, N takes bit 7 of B and V takes bit 6 of B. C passes through, and nothing is written back.
- R7: Codes 7 and 8 add or subtract one from A, wrapping at 8 bits. The value is written back, and only N and Z are updated.
- R8: Code 9 shifts A left and code 10 shifts A right, each by one place. The vacated bit is filled with 0, and the bit shifted out goes into C. N and Z come from the written value, and V passes through.
- R9: Code 11 rotates A left and code 12 rotates A right, each by one place. The vacated bit takes the incoming C, the bit shifted out goes into C, N and Z come from the written value, and V passes through.
- R10: Codes 13 to 15 are reserved. They write nothing back, and flagsOut equals flagsIn.
- R11: The flags are packed as bit 3 = N, bit 2 = V, bit 1 = Z, bit 0 = C, on both flagsIn and flagsOut. For every operation that writes back, N is bit 7 of the result and Z is set exactly when the 8-bit result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation selector (codes 0 to 15) |
| opA | input | 8 | Accumulator-side operand |
| opB | input | 8 | Memory-side operand |
| flagsIn | input | 4 | Current flags {N,V,Z,C} |
| result | output | 8 | Registered data result |
| resultWe | output | 1 | Result should be written back |
| flagsOut | output | 4 | Registered updated flags {N,V,Z,C} |
| outValid | output | 1 | Outputs carry a new operation's effect |

## Verification
The hardest behaviour to show from the ports is the flag pass-through. A flag that stays unchanged looks exactly like a flag that was recomputed, unless the incoming value is the opposite of what the operation would have produced. The stimulus therefore pairs each operation with flagsIn patterns chosen against the expected outcome. For example, V is driven high into compares and logic operations, and C is driven both ways into rotates. Signed overflow in add and subtract is reached with operands that sit next to the sign boundary, such as 0x50+0x50 and 0x50-0xB0. Those results are checked against a reference that works on full-width signed integers rather than on sign bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  // Bit positions of the flags inside the 4-bit flag vectors.
  localparam int FLAG_N = 3;
  localparam int FLAG_V = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_BIT  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_ROL  = 4'd11,
    OP_ROR  = 4'd12
  } aluOp_e;

  typedef enum logic [2:0] {
    UNIT_NONE,
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_STEP,
    UNIT_SHIFT,
    UNIT_TEST
  } aluUnit_e;

  typedef enum logic [1:0] {
    LOGIC_AND = 2'd0,
    LOGIC_OR  = 2'd1,
    LOGIC_XOR = 2'd2
  } logicSel_e;

  // Strobes handed from control to datapath.
  typedef struct packed {
    logic      load;
    aluUnit_e  unitSel;
    logic      invertB;
    logic      forceCarry;
    logicSel_e logicSel;
    logic      stepDown;
    logic      shiftLeft;
    logic      rotate;
    logic      wrEn;
    logic      updN;
    logic      updV;
    logic      updZ;
    logic      updC;
  } aluStrobe_t;

endpackage

// File: rtl/alu8_ctrl.sv
module alu8_ctrl
  import alu8_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output aluStrobe_t strobes
);

  always_comb begin
    strobes            = '0;
    strobes.load       = opValid;
    strobes.unitSel    = UNIT_NONE;
    strobes.logicSel   = LOGIC_AND;
    case (opCode)
      OP_ADD: begin
        strobes.unitSel = UNIT_ARITH;
        strobes.wrEn    = 1'b1;
        strobes.updN    = 1'b1;
        strobes.updV    = 1'b1;
        strobes.updZ    = 1'b1;
        strobes.updC    = 1'b1;
      end
      OP_SUB: begin
        strobes.unitSel = UNIT_ARITH;
        strobes.invertB = 1'b1;
        strobes.wrEn    = 1'b1;
        strobes.updN    = 1'b1;
        strobes.updV    = 1'b1;
        strobes.updZ    = 1'b1;
        strobes.updC    = 1'b1;
      end
      OP_CMP: begin
        strobes.unitSel    = UNIT_ARITH;
        strobes.invertB    = 1'b1;
        strobes.forceCarry = 1'b1;
        strobes.updN       = 1'b1;
        strobes.updZ       = 1'b1;
        strobes.updC       = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        strobes.unitSel  = UNIT_LOGIC;
        strobes.logicSel = (opCode == OP_AND) ? LOGIC_AND :
                           (opCode == OP_OR)  ? LOGIC_OR  : LOGIC_XOR;
        strobes.wrEn     = 1'b1;
        strobes.updN     = 1'b1;
        strobes.updZ     = 1'b1;
      end
      OP_BIT: begin
        strobes.unitSel = UNIT_TEST;
        strobes.updN    = 1'b1;
        strobes.updV    = 1'b1;
        strobes.updZ    = 1'b1;
      end
      OP_INC, OP_DEC: begin
        strobes.unitSel  = UNIT_STEP;
        strobes.stepDown = (opCode == OP_DEC);
        strobes.wrEn     = 1'b1;
        strobes.updN     = 1'b1;
        strobes.updZ     = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        strobes.unitSel   = UNIT_SHIFT;
        strobes.shiftLeft = (opCode == OP_SHL) || (opCode == OP_ROL);
        strobes.rotate    = (opCode == OP_ROL) || (opCode == OP_ROR);
        strobes.wrEn      = 1'b1;
        strobes.updN      = 1'b1;
        strobes.updZ      = 1'b1;
        strobes.updC      = 1'b1;
      end
      default: begin
        strobes.unitSel = UNIT_NONE;
      end
    endcase
  end

endmodule

// File: rtl/alu8_dp.sv
module alu8_dp
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluStrobe_t        strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [3:0]        flagsOut,
  output logic              outValid
);

  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic              carryIn;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   sumWide;
  logic              arithV;
  logic [DATA_W-1:0] logicRes;
  logic [DATA_W-1:0] stepRes;
  logic [DATA_W-1:0] shiftRes;
  logic              shiftOut;
  logic              shiftFill;
  logic [DATA_W-1:0] testAnd;
  logic [DATA_W-1:0] unitRes;
  logic [DATA_W-1:0] zeroSrc;
  logic              newN, newV, newZ, newC;
  logic [3:0]        nextFlags;

  // Adder shared by add, subtract and compare.
  always_comb begin
    bEff    = strobes.invertB ? ~opB : opB;
    carryIn = strobes.forceCarry ? 1'b1 : flagsIn[FLAG_C];
    sumWide = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, carryIn};
    arithV  = (opA[MSB] == bEff[MSB]) && (sumWide[MSB] != opA[MSB]);
  end

  always_comb begin
    case (strobes.logicSel)
      LOGIC_OR:  logicRes = opA | opB;
      LOGIC_XOR: logicRes = opA ^ opB;
      default:   logicRes = opA & opB;
    endcase
  end

  assign stepRes = strobes.stepDown ? (opA - ONE) : (opA + ONE);
  assign testAnd = opA & opB;

  // One-place shifter; rotate picks the fill bit from the old carry.
  assign shiftFill = strobes.rotate ? flagsIn[FLAG_C] : 1'b0;
  always_comb begin
    if (strobes.shiftLeft) begin
      shiftRes = {opA[MSB-1:0], shiftFill};
      shiftOut = opA[MSB];
    end else begin
      shiftRes = {shiftFill, opA[MSB:1]};
      shiftOut = opA[0];
    end
  end

  always_comb begin
    unitRes = '0;
    newV    = flagsIn[FLAG_V];
    newC    = flagsIn[FLAG_C];
    case (strobes.unitSel)
      UNIT_ARITH: begin
        unitRes = sumWide[MSB:0];
        newV    = arithV;
        newC    = sumWide[DATA_W];
      end
      UNIT_LOGIC: unitRes = logicRes;
      UNIT_STEP:  unitRes = stepRes;
      UNIT_SHIFT: begin
        unitRes = shiftRes;
        newC    = shiftOut;
      end
      UNIT_TEST: begin
        unitRes = testAnd;
        newV    = opB[MSB-1];
      end
      default: unitRes = '0;
    endcase
    zeroSrc = unitRes;
    newN    = (strobes.unitSel == UNIT_TEST) ? opB[MSB] : unitRes[MSB];
    newZ    = (zeroSrc == '0);
  end

  always_comb begin
    nextFlags         = flagsIn;
    nextFlags[FLAG_N] = strobes.updN ? newN : flagsIn[FLAG_N];
    nextFlags[FLAG_V] = strobes.updV ? newV : flagsIn[FLAG_V];
    nextFlags[FLAG_Z] = strobes.updZ ? newZ : flagsIn[FLAG_Z];
    nextFlags[FLAG_C] = strobes.updC ? newC : flagsIn[FLAG_C];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      resultWe <= 1'b0;
      flagsOut <= '0;
      outValid <= 1'b0;
    end else if (strobes.load) begin
      if (strobes.wrEn) begin
        result <= unitRes;
      end
      resultWe <= strobes.wrEn;
      flagsOut <= nextFlags;
      outValid <= 1'b1;
    end else begin
      resultWe <= 1'b0;
      outValid <= 1'b0;
    end
  end

endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [3:0]        flagsOut,
  output logic              outValid
);

  aluStrobe_t strobes;

  alu8_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobes (strobes)
  );

  alu8_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .flagsIn  (flagsIn),
    .result   (result),
    .resultWe (resultWe),
    .flagsOut (flagsOut),
    .outValid (outValid)
  );

endmodule

// File: rtl/alu8_chk.sv
module alu8_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic [DATA_W-1:0] opA,
  input logic [3:0]        flagsIn,
  input logic [DATA_W-1:0] result,
  input logic              resultWe,
  input logic [3:0]        flagsOut,
  input logic              outValid
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!outValid && !resultWe));

  assert_we_implies_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    resultWe |-> outValid);

  assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd2) |=> (!resultWe && $stable(result)));

  assert_logic_keeps_vc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && (opCode == 4'd3 || opCode == 4'd4 || opCode == 4'd5)) |=>
      (flagsOut[2] == $past(flagsIn[2]) && flagsOut[0] == $past(flagsIn[0])));

  assert_shl_carry_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 4'd9) |=> (flagsOut[0] == $past(opA[DATA_W-1])));

  assert_reserved_passthru_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode >= 4'd13) |=> (!resultWe && flagsOut == $past(flagsIn)));

  assert_nz_track_R11: assert property (@(posedge clk) disable iff (!rstN)
    resultWe |-> (flagsOut[3] == result[DATA_W-1] && flagsOut[1] == (result == '0)));

endmodule

bind alu8_flags alu8_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .opValid  (opValid),
  .opCode   (opCode),
  .opA      (opA),
  .flagsIn  (flagsIn),
  .result   (result),
  .resultWe (resultWe),
  .flagsOut (flagsOut),
  .outValid (outValid)
);

// File: tb/tb_alu8_flags.sv
module tb_alu8_flags;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [3:0] opCode = '0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [3:0] flagsIn = '0;
  logic [7:0] result;
  logic       resultWe;
  logic [3:0] flagsOut;
  logic       outValid;

  int checks = 0;
  int fails = 0;
  logic [7:0] expRes = '0;
  logic [3:0] expFlags = '0;

  always #5 clk = ~clk;

  alu8_flags dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opA(opA), .opB(opB), .flagsIn(flagsIn), .result(result),
    .resultWe(resultWe), .flagsOut(flagsOut), .outValid(outValid)
  );

  // Reference: returns {we, value, N, V, Z, C}; flags packed per R11.
  function automatic logic [12:0] refModel(input logic [3:0] op, input logic [7:0] a,
                                           input logic [7:0] b, input logic [3:0] f);
    logic n, v, z, c, cin, we;
    logic [7:0] r;
    int s, sv;
    n = f[3]; v = f[2]; z = f[1]; c = f[0]; cin = f[0];
    r = 8'h00; we = 1'b0;
    case (op)
      4'd0: begin
        s = int'(a) + int'(b) + int'(cin);
        sv = int'($signed(a)) + int'($signed(b)) + int'(cin);
        r = s[7:0]; c = (s > 255); v = (sv < -128) || (sv > 127); we = 1'b1;
      end
      4'd1: begin
        s = int'(a) - int'(b) - (1 - int'(cin));
        sv = int'($signed(a)) - int'($signed(b)) - (1 - int'(cin));
        r = s[7:0]; c = (s >= 0); v = (sv < -128) || (sv > 127); we = 1'b1;
      end
      4'd2: begin
        s = int'(a) - int'(b);
        n = s[7]; z = (a == b); c = (a >= b);
      end
      4'd3: begin r = a & b; we = 1'b1; end
      4'd4: begin r = a | b; we = 1'b1; end
      4'd5: begin r = a ^ b; we = 1'b1; end
      4'd6: begin n = b[7]; v = b[6]; z = ((a & b) == 8'h00); end
      4'd7: begin r = a + 8'd1; we = 1'b1; end
      4'd8: begin r = a - 8'd1; we = 1'b1; end
      4'd9:  begin r = {a[6:0], 1'b0}; c = a[7]; we = 1'b1; end
      4'd10: begin r = {1'b0, a[7:1]}; c = a[0]; we = 1'b1; end
      4'd11: begin r = {a[6:0], cin};  c = a[7]; we = 1'b1; end
      4'd12: begin r = {cin, a[7:1]};  c = a[0]; we = 1'b1; end
      default: ;
    endcase
    if (we) begin
      n = r[7]; z = (r == 8'h00);
    end
    return {we, r, n, v, z, c};
  endfunction

  task automatic check(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {valid,we,result,flags} actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, sample after the next rising edge.
  task automatic runOp(input string req, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [3:0] f);
    logic [12:0] m;
    @(negedge clk);
    opValid = 1'b1; opCode = op; opA = a; opB = b; flagsIn = f;
    m = refModel(op, a, b, f);
    @(posedge clk); #1;
    if (m[12]) expRes = m[11:4];
    expFlags = m[3:0];
    // R11 packing and N/Z tracking are covered by every comparison here.
    check(req, {outValid, resultWe, result, flagsOut}, {1'b1, m[12], expRes, expFlags});
  endtask

  task automatic testReset;
    #1;
    check("R1", {outValid, resultWe, result, flagsOut}, 14'h0);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic testAddSub;
    logic [7:0] x = 8'h3b, y = 8'hc5;
    runOp("R3 add overflow", 4'd0, 8'h50, 8'h50, 4'b0000);
    runOp("R3 add carry zero", 4'd0, 8'hff, 8'h01, 4'b0000);
    runOp("R3 add carry-in", 4'd0, 8'h10, 8'h20, 4'b0001);
    runOp("R3 sub overflow", 4'd1, 8'h50, 8'hb0, 4'b0001);
    runOp("R3 sub borrow", 4'd1, 8'h00, 8'h01, 4'b0001);
    runOp("R3 sub borrow-in", 4'd1, 8'h05, 8'h05, 4'b0000);
    runOp("R3 sub neg overflow", 4'd1, 8'h80, 8'h01, 4'b0001);
    for (int i = 0; i < 24; i++) begin
      x = x * 8'd13 + 8'd7;
      y = {y[6:0], y[7] ^ y[5]} + 8'd3;
      runOp("R3 sweep", 4'(i % 2), x, y, 4'(i));
    end
  endtask

  task automatic testCompare;
    runOp("R4 equal", 4'd2, 8'h42, 8'h42, 4'b0100);
    runOp("R4 less", 4'd2, 8'h10, 8'h20, 4'b0101);
    runOp("R4 greater", 4'd2, 8'hf0, 8'h01, 4'b0110);
  endtask

  task automatic testLogic;
    runOp("R5 and", 4'd3, 8'hf0, 8'h0f, 4'b0101);
    runOp("R5 or", 4'd4, 8'h80, 8'h01, 4'b0111);
    runOp("R5 xor", 4'd5, 8'haa, 8'h55, 4'b0010);
  endtask

  task automatic testBit;
    runOp("R6 bit zero", 4'd6, 8'h01, 8'hc0, 4'b0001);
    runOp("R6 bit nonzero", 4'd6, 8'hff, 8'h01, 4'b1110);
  endtask

  task automatic testIncDec;
    runOp("R7 inc wrap", 4'd7, 8'hff, 8'h00, 4'b0101);
    runOp("R7 inc sign", 4'd7, 8'h7f, 8'h00, 4'b0000);
    runOp("R7 dec wrap", 4'd8, 8'h00, 8'h00, 4'b0111);
    runOp("R7 dec zero", 4'd8, 8'h01, 8'h00, 4'b1001);
  endtask

  task automatic testShift;
    runOp("R8 shl out", 4'd9, 8'h81, 8'h00, 4'b0100);
    runOp("R8 shl zero", 4'd9, 8'h80, 8'h00, 4'b0001);
    runOp("R8 shr", 4'd10, 8'h03, 8'h00, 4'b1001);
    runOp("R8 shr fill", 4'd10, 8'h80, 8'h00, 4'b0101);
  endtask

  task automatic testRotate;
    runOp("R9 rol c1", 4'd11, 8'h40, 8'h00, 4'b0001);
    runOp("R9 rol c0", 4'd11, 8'h80, 8'h00, 4'b0000);
    runOp("R9 ror c1", 4'd12, 8'h02, 8'h00, 4'b0001);
    runOp("R9 ror c0", 4'd12, 8'h01, 8'h00, 4'b0100);
  endtask

  task automatic testReserved;
    runOp("R10 code13", 4'd13, 8'h12, 8'h34, 4'b1010);
    runOp("R10 code14", 4'd14, 8'h00, 8'h00, 4'b0101);
    runOp("R10 code15", 4'd15, 8'hff, 8'hff, 4'b1111);
  endtask

  task automatic testIdle;
    runOp("R2 prime", 4'd3, 8'h3c, 8'hff, 4'b0000);
    @(negedge clk);
    opValid = 1'b0; opCode = 4'd0; opA = 8'h77; flagsIn = 4'b1111;
    @(posedge clk); #1;
    check("R2 idle", {outValid, resultWe, result, flagsOut}, {2'b00, expRes, expFlags});
    @(posedge clk); #1;
    check("R2 idle hold", {outValid, resultWe, result, flagsOut}, {2'b00, expRes, expFlags});
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    testAddSub();
    testCompare();
    testLogic();
    testBit();
    testIncDec();
    testShift();
    testRotate();
    testReserved();
    testIdle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule